// File: doc/BRIEF.md
# Calendar Real-Time Clock with Masked Alarm

This block keeps wall-clock time and a calendar date inside a synchronous design. A one-cycle enable arriving at 32.768 kHz (or any power-of-two rate set by a parameter) drives a sub-second counter. When that counter wraps, the time advances by one second, and the carry ripples through minutes, hours, day, month and a two-digit year. Month lengths are built in. February gains its 29th day in every year whose two-digit value is a multiple of four, which covers the 2000 to 2099 span.

Software loads every field through a single-cycle write port. The same port sets up a six-field alarm with a per-field ignore mask, and a control byte that selects the hour display format and one of eight periodic tick rates. Internally the hour is always kept in 24-hour form. In 12-hour mode, hour writes are converted on the way in and the hour output is converted on the way out. The alarm output pulses for one cycle in the second whose new time matches every field that is not masked. The tick output pulses for one cycle at the chosen fraction of a second.

Top module: `cal_rtc`

## Requirements
- R1: After reset the clock reads 00:00:00 on day 1, month 1, year 0. The mode is 24-hour, the tick rate code is 7, all alarm fields and mask bits are 0, and both interrupt outputs are low.
- R2: The seconds field advances exactly once every PRESC_DIV cycles in which rtc_en is high. A write to address 0 (seconds) clears the sub-second phase, so the next advance comes exactly PRESC_DIV enabled cycles after that write.
- R3: Seconds and minutes roll from 59 to 0 and carry into the next field. Hours roll from 23 to 0 and carry into the day.
- R4: Day rolls to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. Month 12 rolls to month 1.
- R5: In month 2 the last day is 29 when the year value is a multiple of 4 (0 included), and 28 otherwise. Year 99 rolls to 0.
- R6: Control address 13 bit 3 selects 12-hour mode. In that mode hour_o reads 12 for internal hours 0 and 12, and h-12 for hours 13 to 23. Hour writes take the hour in bits 3:0 (1 to 12) and PM in bit 7. pm_o is high whenever the internal hour is 12 or more.
- R7: alarm_irq goes high for one cycle, one cycle after the second update, when the new time equals the alarm on every unmasked field. Alarm fields sit at addresses 6 to 11 in the order second, minute, hour, day, month, year.
- R8: Mask address 12 bit i (bit 0 second through bit 5 year) removes field i from the alarm compare. A mismatch in an unmasked field suppresses the pulse. With every bit set, the alarm pulses every second.
- R9: Control bits 2:0 pick tick code s. tick_irq pulses for one cycle every PRESC_DIV>>(7-s) enabled cycles, in phase with the seconds counter: code 0 is 1/128 s and code 7 is 1 s.
- R10: Writes to addresses 14 and 15 change no time field, alarm field or control bit.
- R11: While rtc_en is low, no time field changes except by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_en | input | 1 | One-cycle enable at the reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write value |
| sec_o | output | 6 | Seconds 0..59 |
| min_o | output | 6 | Minutes 0..59 |
| hour_o | output | 5 | Hour in the selected display format |
| pm_o | output | 1 | High for afternoon hours |
| day_o | output | 5 | Day of month |
| month_o | output | 4 | Month 1..12 |
| year_o | output | 7 | Two-digit year 0..99 |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| tick_irq | output | 1 | One-cycle periodic tick |

## Verification
A wrong sub-second count shows up as a seconds update one or more cycles away from the enabled-cycle count after a seconds write, so edges one cycle either side of that point are checked. A wrong month-length or leap decision stays hidden until a day rollover, so the stimulus loads the last second of each month class and reads the date on the very next update. A broken mask or compare shows up as a missing or extra alarm pulse within the second after the match. A wrong tick tap shows up as a wrong pulse count over one full second.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

   localparam int NFLD = 6;
   localparam int FW   = 7;

   typedef logic [FW-1:0] fld_t;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] month;
      logic [4:0] day;
      logic [4:0] hour;
      logic [5:0] minute;
      logic [5:0] second;
   } cal_time_t;

   localparam logic [3:0] ADR_SEC   = 4'd0;
   localparam logic [3:0] ADR_HOUR  = 4'd2;
   localparam logic [3:0] ADR_AHOUR = 4'd8;
   localparam logic [3:0] ADR_MASK  = 4'd12;
   localparam logic [3:0] ADR_CTRL  = 4'd13;

   localparam cal_time_t TIME_RESET = '{year: 7'd0, month: 4'd1, day: 5'd1,
                                        hour: 5'd0, minute: 6'd0, second: 6'd0};

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
      case (mon)
         4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction

   function automatic fld_t hour_in(input logic [7:0] d, input logic m12);
      if (!m12)              return {2'b00, d[4:0]};
      if (d[3:0] == 4'd12)   return d[7] ? 7'd12 : 7'd0;
      if (d[7])              return {3'b000, d[3:0]} + 7'd12;
      return {3'b000, d[3:0]};
   endfunction

   function automatic logic [4:0] hour_out(input logic [4:0] h, input logic m12);
      if (!m12)        return h;
      if (h == 5'd0)   return 5'd12;
      if (h > 5'd12)   return h - 5'd12;
      return h;
   endfunction

   function automatic fld_t get_fld(input cal_time_t t, input int idx);
      case (idx)
         0:       return {1'b0, t.second};
         1:       return {1'b0, t.minute};
         2:       return {2'b00, t.hour};
         3:       return {2'b00, t.day};
         4:       return {3'b000, t.month};
         default: return t.year;
      endcase
   endfunction

   function automatic cal_time_t put_fld(input cal_time_t t, input int idx, input fld_t v);
      cal_time_t r;
      r = t;
      case (idx)
         0:       r.second = v[5:0];
         1:       r.minute = v[5:0];
         2:       r.hour   = v[4:0];
         3:       r.day    = v[4:0];
         4:       r.month  = v[3:0];
         default: r.year   = v;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       clr,
   input  logic [2:0] tick_sel,
   output logic       sec_step,
   output logic       tick_irq
);
   localparam int SW = $clog2(DIV);

   if (DIV < 256 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
      $error("cal_rtc_prescaler: DIV must be a power of two of at least 256");
   end

   logic [SW-1:0] sub;
   logic [7:0]    rate_hit;

   // Each tick rate is a run of low bits of the shared phase counter, all ones.
   for (genvar i = 0; i < 8; i++) begin : g_rate
      localparam int LG = SW - 7 + i;
      assign rate_hit[i] = &sub[LG-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sub <= '0;
      else if (clr)    sub <= '0;
      else if (en)     sub <= sub + 1'b1;
   end

   assign sec_step = en & ~clr & (&sub);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_irq <= 1'b0;
      else        tick_irq <= en & ~clr & rate_hit[tick_sel];
   end
endmodule

// File: rtl/cal_rtc_timekeeper.sv
module cal_rtc_timekeeper
   import cal_rtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [NFLD-1:0] we,
   input  fld_t            val,
   output cal_time_t       now
);
   cal_time_t nxt;

   always_comb begin
      nxt = now;
      if (step) begin
         if (now.second >= 6'd59) begin
            nxt.second = '0;
            if (now.minute >= 6'd59) begin
               nxt.minute = '0;
               if (now.hour >= 5'd23) begin
                  nxt.hour = '0;
                  if (now.day >= month_days(now.month, now.year)) begin
                     nxt.day = 5'd1;
                     if (now.month >= 4'd12) begin
                        nxt.month = 4'd1;
                        nxt.year  = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
                     end else begin
                        nxt.month = now.month + 4'd1;
                     end
                  end else begin
                     nxt.day = now.day + 5'd1;
                  end
               end else begin
                  nxt.hour = now.hour + 5'd1;
               end
            end else begin
               nxt.minute = now.minute + 6'd1;
            end
         end else begin
            nxt.second = now.second + 6'd1;
         end
      end
      for (int i = 0; i < NFLD; i++) begin
         if (we[i]) nxt = put_fld(nxt, i, val);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= TIME_RESET;
      else        now <= nxt;
   end
endmodule

// File: rtl/cal_rtc_alarm.sv
module cal_rtc_alarm
   import cal_rtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [NFLD-1:0] we,
   input  fld_t            val,
   input  logic            mask_we,
   input  logic [NFLD-1:0] mask_val,
   input  cal_time_t       now,
   output logic            alarm_irq
);
   cal_time_t       alm;
   logic [NFLD-1:0] ignore;
   logic [NFLD-1:0] fld_ok;
   logic            step_q;

   for (genvar i = 0; i < NFLD; i++) begin : g_cmp
      assign fld_ok[i] = ignore[i] | (get_fld(now, i) == get_fld(alm, i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm    <= '0;
         ignore <= '0;
      end else begin
         for (int i = 0; i < NFLD; i++) begin
            if (we[i]) alm <= put_fld(alm, i, val);
         end
         if (mask_we) ignore <= mask_val;
      end
   end

   // Compare against the registers after they took the new second (R7).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q    <= 1'b0;
         alarm_irq <= 1'b0;
      end else begin
         step_q    <= step;
         alarm_irq <= step_q & (&fld_ok);
      end
   end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
   import cal_rtc_pkg::*;
#(
   parameter int unsigned PRESC_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rtc_en,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [5:0] sec_o,
   output logic [5:0] min_o,
   output logic [4:0] hour_o,
   output logic       pm_o,
   output logic [4:0] day_o,
   output logic [3:0] month_o,
   output logic [6:0] year_o,
   output logic       alarm_irq,
   output logic       tick_irq
);
   logic [NFLD-1:0] tm_we;
   logic [NFLD-1:0] al_we;
   fld_t            wval;
   logic            phase_clr;
   logic            sec_step;
   logic [2:0]      tick_sel;
   logic            mode12;
   cal_time_t       now;

   always_comb begin
      tm_we = '0;
      al_we = '0;
      for (int i = 0; i < NFLD; i++) begin
         tm_we[i] = wr_en && (wr_addr == 4'(i));
         al_we[i] = wr_en && (wr_addr == 4'(i + NFLD));
      end
   end

   assign wval      = (wr_addr == ADR_HOUR || wr_addr == ADR_AHOUR) ? hour_in(wr_data, mode12)
                                                                   : wr_data[6:0];
   assign phase_clr = wr_en && (wr_addr == ADR_SEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_sel <= 3'd7;
         mode12   <= 1'b0;
      end else if (wr_en && wr_addr == ADR_CTRL) begin
         tick_sel <= wr_data[2:0];
         mode12   <= wr_data[3];
      end
   end

   cal_rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rtc_en),
      .clr      (phase_clr),
      .tick_sel (tick_sel),
      .sec_step (sec_step),
      .tick_irq (tick_irq)
   );

   cal_rtc_timekeeper u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (sec_step),
      .we    (tm_we),
      .val   (wval),
      .now   (now)
   );

   cal_rtc_alarm u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (sec_step),
      .we        (al_we),
      .val       (wval),
      .mask_we   (wr_en && wr_addr == ADR_MASK),
      .mask_val  (wr_data[NFLD-1:0]),
      .now       (now),
      .alarm_irq (alarm_irq)
   );

   assign sec_o   = now.second;
   assign min_o   = now.minute;
   assign hour_o  = hour_out(now.hour, mode12);
   assign pm_o    = now.hour >= 5'd12;
   assign day_o   = now.day;
   assign month_o = now.month;
   assign year_o  = now.year;
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rtc_en,
   input logic       wr_en,
   input logic       sec_step,
   input logic       mode12,
   input logic [5:0] sec_o,
   input logic [5:0] min_o,
   input logic [4:0] hour_o,
   input logic [3:0] month_o,
   input logic       alarm_irq,
   input logic       tick_irq
);
   a_r3_fields_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      sec_o < 6'd60 && min_o < 6'd60);

   a_r6_hour12_range: assert property (@(posedge clk) disable iff (!rst_n)
      mode12 |-> (hour_o >= 5'd1 && hour_o <= 5'd12));

   a_r6_hour24_range: assert property (@(posedge clk) disable iff (!rst_n)
      !mode12 |-> hour_o < 5'd24);

   a_r2_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$past(sec_step)) |-> $stable(sec_o));

   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rtc_en) && !$past(wr_en)) |-> ($stable(sec_o) && $stable(min_o)));

   a_r4_month_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(month_o) == 4'd12 && month_o != 4'd12 && !$past(wr_en)) |-> month_o == 4'd1);

   a_r7_alarm_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |=> !alarm_irq);

   a_r7_alarm_after_step: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> $past(sec_step, 2));

   a_r9_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);
endmodule

bind cal_rtc cal_rtc_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rtc_en    (rtc_en),
   .wr_en     (wr_en),
   .sec_step  (sec_step),
   .mode12    (mode12),
   .sec_o     (sec_o),
   .min_o     (min_o),
   .hour_o    (hour_o),
   .month_o   (month_o),
   .alarm_irq (alarm_irq),
   .tick_irq  (tick_irq)
);

// File: tb/sim_cal_rtc.sv
`timescale 1ns/1ps
module sim_cal_rtc;
   localparam int DIV = 256;
   localparam int K_TIME = 0, K_ALARM = 1, K_TICK = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rtc_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] sec_o, min_o;
   logic [4:0] hour_o, day_o;
   logic       pm_o, alarm_irq, tick_irq;
   logic [3:0] month_o;
   logic [6:0] year_o;

   always #2 clk = ~clk;

   cal_rtc #(.PRESC_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .pm_o(pm_o),
      .day_o(day_o), .month_o(month_o), .year_o(year_o), .alarm_irq(alarm_irq),
      .tick_irq(tick_irq)
   );

   typedef struct {
      string tag;
      int    kind;
      int    a[7];
      int    base;
   } item_t;

   item_t q[$];
   int    n_run = 0, n_fail = 0;
   int    alarm_cnt = 0, tick_cnt = 0;
   bit    mode12 = 0;
   bit    done = 0;

   always @(posedge clk) begin
      if (alarm_irq) alarm_cnt++;
      if (tick_irq)  tick_cnt++;
   end

   // Monitor: pops expected items and compares with the ports
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_run++;
         if (it.kind == K_TIME) begin
            if (hour_o != it.a[0] || pm_o != it.a[1] || min_o != it.a[2] || sec_o != it.a[3] ||
                day_o != it.a[4] || month_o != it.a[5] || year_o != it.a[6]) begin
               n_fail++;
               $display("FAIL %s: got %0d:%0d:%0d pm=%0d %0d/%0d/%0d exp %0d:%0d:%0d pm=%0d %0d/%0d/%0d",
                        it.tag, hour_o, min_o, sec_o, pm_o, day_o, month_o, year_o,
                        it.a[0], it.a[2], it.a[3], it.a[1], it.a[4], it.a[5], it.a[6]);
            end
         end else begin
            int got;
            got = (it.kind == K_ALARM ? alarm_cnt : tick_cnt) - it.base;
            if (got != it.a[0]) begin
               n_fail++;
               $display("FAIL %s: pulse count got %0d exp %0d", it.tag, got, it.a[0]);
            end
         end
      end
   end

   function automatic int hdisp(int h);
      if (!mode12) return h;
      if (h == 0) return 12;
      return (h > 12) ? h - 12 : h;
   endfunction

   function automatic int henc(int h);
      if (!mode12) return h;
      if (h == 0)  return 12;
      if (h == 12) return 8'h80 | 12;
      return (h > 12) ? (8'h80 | (h - 12)) : h;
   endfunction

   task automatic push_time(string tag, int y, int mo, int d, int h, int mi, int s);
      item_t it;
      it.tag = tag; it.kind = K_TIME; it.base = 0;
      it.a = '{hdisp(h), (h >= 12) ? 1 : 0, mi, s, d, mo, y};
      q.push_back(it);
   endtask

   task automatic push_cnt(string tag, int kind, int exp, int base);
      item_t it;
      it.tag = tag; it.kind = kind; it.base = base;
      it.a = '{exp, 0, 0, 0, 0, 0, 0};
      q.push_back(it);
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // seconds written first to hold off any carry, and last to set the phase
   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      wr(0, 0); wr(5, y); wr(4, mo); wr(3, d); wr(2, henc(h)); wr(1, mi); wr(0, s);
   endtask

   task automatic step(string tag, int y, int mo, int d, int h, int mi, int s,
                       int ny, int nmo, int nd, int nh, int nmi, int ns);
      set_time(y, mo, d, h, mi, s);
      repeat (DIV - 1) @(posedge clk);
      #1 push_time(tag, y, mo, d, h, mi, s);
      @(posedge clk);
      #1 push_time(tag, ny, nmo, nd, nh, nmi, ns);
   endtask

   task automatic alarm_window(string tag, int cycles, int exp);
      int base;
      set_time(21, 3, 3, 8, 30, 14);
      base = alarm_cnt;
      repeat (cycles) @(posedge clk);
      #1 push_cnt(tag, K_ALARM, exp, base);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1 push_time("R1 reset", 0, 1, 1, 0, 0, 0);
      n_run++;
      if (alarm_irq !== 1'b0 || tick_irq !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 irqs: got %b%b exp 00", alarm_irq, tick_irq);
      end

      step("R2 phase", 24, 6, 15, 10, 20, 30, 24, 6, 15, 10, 20, 31);
      step("R3 carry", 24, 6, 15, 13, 59, 59, 24, 6, 15, 14, 0, 0);
      step("R5 year wrap", 99, 12, 31, 23, 59, 59, 0, 1, 1, 0, 0, 0);
      step("R4 april", 10, 4, 30, 23, 59, 59, 10, 5, 1, 0, 0, 0);
      step("R4 jan30", 10, 1, 30, 23, 59, 59, 10, 1, 31, 0, 0, 0);
      step("R4 jan31", 10, 1, 31, 23, 59, 59, 10, 2, 1, 0, 0, 0);
      step("R5 leap28", 24, 2, 28, 23, 59, 59, 24, 2, 29, 0, 0, 0);
      step("R5 common28", 23, 2, 28, 23, 59, 59, 23, 3, 1, 0, 0, 0);
      step("R5 leap29", 24, 2, 29, 23, 59, 59, 24, 3, 1, 0, 0, 0);
      step("R5 year0", 0, 2, 28, 23, 59, 59, 0, 2, 29, 0, 0, 0);

      wr(13, 8'h0F); mode12 = 1;
      step("R6 midnight", 5, 5, 5, 23, 59, 59, 5, 5, 6, 0, 0, 0);
      step("R6 noon", 5, 5, 5, 11, 59, 59, 5, 5, 5, 12, 0, 0);
      step("R6 12am", 5, 5, 5, 0, 0, 0, 5, 5, 5, 0, 0, 1);
      wr(13, 8'h07); mode12 = 0;

      // R10: unused addresses
      set_time(30, 7, 7, 7, 7, 7);
      wr(14, 8'h3F); wr(15, 8'h11);
      @(posedge clk);
      #1 push_time("R10 ignored", 30, 7, 7, 7, 7, 7);

      // R11: enable held low
      set_time(31, 8, 9, 9, 9, 9);
      @(negedge clk) rtc_en = 1'b0;
      repeat (600) @(posedge clk);
      #1 push_time("R11 frozen", 31, 8, 9, 9, 9, 9);
      @(negedge clk) rtc_en = 1'b1;

      // R7 / R8: alarm at 08:30:15 3/3/21
      wr(6, 15); wr(7, 30); wr(8, 8); wr(9, 3); wr(10, 3); wr(11, 21); wr(12, 0);
      alarm_window("R7 match", 300, 1);
      alarm_window("R7 once", 600, 1);
      wr(11, 50); wr(12, 8'h20);
      alarm_window("R8 masked year", 300, 1);
      wr(12, 8'h00);
      alarm_window("R8 unmasked mismatch", 300, 0);
      wr(12, 8'h3F);
      alarm_window("R8 all masked", 520, 2);
      wr(12, 8'h00); wr(9, 0);

      // R9: tick rates
      foreach (sel_list[k]) begin
         int base;
         wr(13, sel_list[k]);
         set_time(1, 1, 1, 1, 1, 1);
         base = tick_cnt;
         repeat (DIV + 1) @(posedge clk);
         #1 push_cnt($sformatf("R9 rate %0d", sel_list[k]), K_TICK, 1 << (7 - sel_list[k]), base);
      end

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   int sel_list[4] = '{0, 3, 5, 7};

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule